// File: doc/BRIEF.md
# Receive Byte Queue with Inactivity Timeout

This block holds up to sixteen received bytes between the line side of a serial controller and the host. The line side offers bytes one per cycle, and a line break arrives as its own strobe. The host pulls bytes out by read requests. The block reports how many bytes it holds and whether it is full or empty. It pulses an overrun flag when a byte arrives with no room for it.

A small control word sets receive enable and receive disable, and disable wins when both are set. A one-shot flush bit in the same word empties the queue. An inactivity timer restarts on every byte that is stored. It raises a one-cycle timeout pulse once four character times pass with no new byte. The character time is worked out from a bit period in clock cycles and the frame shape: data width, optional parity and one or two stop bits.

Top module: `rx_byte_queue`

## Requirements
- R1: Stored bytes are read back in arrival order. `count` gives the occupancy, 0 to 16. `full` is high exactly when `count` is 16, and `empty` is high exactly when `count` is 0.
- R2: A byte offered while `count` is 16 and the queue is enabled is dropped. `ovr_pulse` is then high for the one following cycle, and the inactivity timer is not restarted.
- R3: Control word fields are bit 1 for enable and bit 2 for disable. The queue is enabled only when bit 1 is set and bit 2 is clear. A write of the word takes effect from the next cycle. While the queue is not enabled, line bytes, breaks and reads have no effect: `count` holds, `rd_data` is zero and no overrun is reported.
- R4: `rd_data` presents the oldest byte in the cycle after an accepted `rd_req`, and zero in every other cycle. A read while empty returns zero and changes nothing.
- R5: A `line_brk` strobe stores a single zero byte, whatever is on `line_vld` and `line_byte` in that cycle.
- R6: `tmo_pulse` is high for exactly one cycle, N cycles after the clock edge that stored the most recent byte, where N is four character times. Each stored byte restarts the count. The count is frozen while the queue is not enabled.
- R7: The character time in cycles is `bit_cycles` × (1 + data bits + parity bit + stop bits). Data bits are 8, 7 or 6 for `width_sel` values 0, 1 and 2, and 8 for value 3. `parity_on` adds one bit, and `stop_two` selects two stop bits instead of one.
- R8: A control write with bit 0 set empties the queue and discards any byte offered in that cycle. It also returns 0 for a read in that cycle and cancels a pending timeout. Bit 0 always reads back 0 on `ctrl_q`.
- R9: A read and a write accepted in the same cycle both take effect and leave `count` unchanged. When the queue is full, the read still succeeds and the byte is dropped as in R2.
- R10: After reset the queue is empty and `ctrl_q` is 3'b100, which means disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 3 | Control word: bit 0 flush, bit 1 enable, bit 2 disable |
| ctrl_q | output | 3 | Control word readback, bit 0 always 0 |
| bit_cycles | input | BITW (12) | Bit period in clock cycles, at least 1 |
| width_sel | input | 2 | Data width select |
| parity_on | input | 1 | Frame carries a parity bit |
| stop_two | input | 1 | Frame carries two stop bits |
| line_vld | input | 1 | Line-side byte strobe |
| line_byte | input | 8 | Line-side byte |
| line_brk | input | 1 | Line break strobe |
| rd_req | input | 1 | Host read request |
| rd_data | output | 8 | Byte returned for the previous cycle's read |
| count | output | 5 | Number of bytes held |
| full | output | 1 | Queue holds 16 bytes |
| empty | output | 1 | Queue holds no bytes |
| ovr_pulse | output | 1 | One-cycle overrun pulse |
| tmo_pulse | output | 1 | One-cycle inactivity timeout pulse |

## Verification
The properties assume that `bit_cycles` is never zero and that the frame inputs change only while no byte is awaiting its timeout. A zero bit period would make the reload value wrap. The stimulus keeps the frame settings fixed within each phase and changes them only after the queue has timed out or been flushed. The hold properties take a quiet cycle to mean no control write, because a flush is the only other way `count` can move. The bench therefore issues control writes only in cycles it plans for that purpose.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Bits in one character frame: start + data + optional parity + stop.
  function automatic int unsigned frame_bits(input logic [1:0] wsel,
                                             input logic par,
                                             input logic two);
    int unsigned d;
    case (wsel)
      2'd1:    d = 7;
      2'd2:    d = 6;
      default: d = 8;
    endcase
    return 1 + d + (par ? 1 : 0) + (two ? 2 : 1);
  endfunction

  // Inactivity window: four character times, in clock cycles.
  function automatic int unsigned timeout_cycles(input int unsigned bitc,
                                                 input logic [1:0] wsel,
                                                 input logic par,
                                                 input logic two);
    return 4 * bitc * frame_bits(wsel, par, two);
  endfunction

  typedef struct packed {
    logic dis;
    logic en;
  } rx_ctl_t;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] wdata,
  output logic       live,
  output logic       flush,
  output logic [2:0] rdback
);
  import rxq_pkg::*;

  rx_ctl_t ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q.dis <= 1'b1;
      ctl_q.en  <= 1'b0;
    end else if (wr) begin
      ctl_q.dis <= wdata[2];
      ctl_q.en  <= wdata[1];
    end
  end

  // Disable outranks enable.
  assign live   = ctl_q.en & ~ctl_q.dis;
  // The flush bit acts in its write cycle and is never stored.
  assign flush  = wr & wdata[0];
  assign rdback = {ctl_q.dis, ctl_q.en, 1'b0};

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_byte,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] level,
  output logic          is_full,
  output logic          is_empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wpos;
  logic [PW-1:0] rpos;

  // Read slot sits `level` entries behind the write slot, modulo DEPTH.
  assign rpos     = wpos - PW'(level);
  assign head     = mem[rpos];
  assign is_full  = (level == CW'(DEPTH));
  assign is_empty = (level == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wpos] <= push_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpos  <= '0;
      level <= '0;
    end else if (flush) begin
      wpos  <= '0;
      level <= '0;
    end else begin
      if (push) wpos <= wpos + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int TW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          restart,
  input  logic [TW-1:0] span,
  input  logic          run,
  output logic          fire
);
  logic          armed;
  logic [TW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      left  <= '0;
      fire  <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (flush) begin
        armed <= 1'b0;
      end else if (restart) begin
        armed <= 1'b1;
        left  <= span - 1'b1;
      end else if (armed && run) begin
        if (left == '0) begin
          fire  <= 1'b1;
          armed <= 1'b0;
        end else begin
          left <= left - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int BITW  = 12,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int TW   = BITW + 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_wr,
  input  logic [2:0]      ctrl_wdata,
  output logic [2:0]      ctrl_q,
  input  logic [BITW-1:0] bit_cycles,
  input  logic [1:0]      width_sel,
  input  logic            parity_on,
  input  logic            stop_two,
  input  logic            line_vld,
  input  logic [DW-1:0]   line_byte,
  input  logic            line_brk,
  input  logic            rd_req,
  output logic [DW-1:0]   rd_data,
  output logic [CW-1:0]   count,
  output logic            full,
  output logic            empty,
  output logic            ovr_pulse,
  output logic            tmo_pulse
);
  import rxq_pkg::*;

  logic          live;
  logic          flush;
  logic          offer;
  logic [DW-1:0] offer_byte;
  logic          wr_take;
  logic          rd_take;
  logic          ovr_evt;
  logic [DW-1:0] head;
  logic [TW-1:0] span;

  rxq_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (ctrl_wr),
    .wdata  (ctrl_wdata),
    .live   (live),
    .flush  (flush),
    .rdback (ctrl_q)
  );

  // A break is stored as a zero byte.
  assign offer      = line_vld | line_brk;
  assign offer_byte = line_brk ? '0 : line_byte;

  // Named events for the checker.
  assign wr_take = live & ~flush & offer & ~full;
  assign rd_take = live & ~flush & rd_req & ~empty;
  assign ovr_evt = live & ~flush & offer & full;

  assign span = TW'(timeout_cycles(32'(bit_cycles), width_sel, parity_on, stop_two));

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (wr_take),
    .push_byte (offer_byte),
    .pop       (rd_take),
    .head      (head),
    .level     (count),
    .is_full   (full),
    .is_empty  (empty)
  );

  rxq_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .restart (wr_take),
    .span    (span),
    .run     (live),
    .fire    (tmo_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      ovr_pulse <= 1'b0;
    end else begin
      rd_data   <= rd_take ? head : '0;
      ovr_pulse <= ovr_evt;
    end
  end

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_wr,
  input logic [2:0]    ctrl_wdata,
  input logic [2:0]    ctrl_q,
  input logic          line_vld,
  input logic          line_brk,
  input logic          rd_req,
  input logic [DW-1:0] rd_data,
  input logic [CW-1:0] count,
  input logic          full,
  input logic          empty,
  input logic          ovr_pulse,
  input logic          tmo_pulse,
  input logic          wr_take,
  input logic          rd_take
);
  logic on_q;
  assign on_q = ctrl_q[1] & ~ctrl_q[2];

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R1
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({full, empty}));

  // R3
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_q && !ctrl_wr) |=> ($stable(count) && rd_data == '0 && !ovr_pulse));

  // R2
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && full && (line_vld || line_brk) && !(ctrl_wr && ctrl_wdata[0])) |=> ovr_pulse);

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_req && !line_vld && !line_brk && !ctrl_wr) |=> (rd_data == '0 && empty));

  // R6
  tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |=> !tmo_pulse);

  // R9
  rw_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && rd_take) |=> $stable(count));

  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_wdata[0]) |=> (count == '0 && !ctrl_q[0] && rd_data == '0));

endmodule

bind rx_byte_queue rxq_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_wr    (ctrl_wr),
  .ctrl_wdata (ctrl_wdata),
  .ctrl_q     (ctrl_q),
  .line_vld   (line_vld),
  .line_brk   (line_brk),
  .rd_req     (rd_req),
  .rd_data    (rd_data),
  .count      (count),
  .full       (full),
  .empty      (empty),
  .ovr_pulse  (ovr_pulse),
  .tmo_pulse  (tmo_pulse),
  .wr_take    (wr_take),
  .rd_take    (rd_take)
);

// File: tb/sim_rx_byte_queue.sv
`timescale 1ns/1ps
module sim_rx_byte_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [2:0]  ctrl_wdata = '0;
  logic [2:0]  ctrl_q;
  logic [11:0] bit_cycles = 12'd2;
  logic [1:0]  width_sel = 2'd0;
  logic        parity_on = 1'b0;
  logic        stop_two = 1'b0;
  logic        line_vld = 1'b0;
  logic [7:0]  line_byte = '0;
  logic        line_brk = 1'b0;
  logic        rd_req = 1'b0;
  logic [7:0]  rd_data;
  logic [4:0]  count;
  logic        full, empty, ovr_pulse, tmo_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string phase = "R10";

  always #5 clk = ~clk;

  rx_byte_queue u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_q(ctrl_q), .bit_cycles(bit_cycles), .width_sel(width_sel),
    .parity_on(parity_on), .stop_two(stop_two), .line_vld(line_vld),
    .line_byte(line_byte), .line_brk(line_brk), .rd_req(rd_req),
    .rd_data(rd_data), .count(count), .full(full), .empty(empty),
    .ovr_pulse(ovr_pulse), .tmo_pulse(tmo_pulse)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] q[$];
  bit m_en = 0, m_dis = 1;
  bit m_armed = 0;
  int m_left = 0;
  logic [7:0] e_rd = 0;
  bit e_ovr = 0, e_tmo = 0;

  function automatic int char_time();
    int data_w;
    data_w = (width_sel == 2'd3) ? 8 : 8 - int'(width_sel);
    return int'(bit_cycles) * (data_w + 2 + int'(parity_on) + int'(stop_two));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_en = 0; m_dis = 1; m_armed = 0; m_left = 0;
      e_rd = 0; e_ovr = 0; e_tmo = 0;
    end else begin
      bit on, incoming;
      logic [7:0] b;
      on = m_en && !m_dis;
      incoming = line_vld || line_brk;
      b = line_brk ? 8'h00 : line_byte;
      e_rd = 0; e_ovr = 0; e_tmo = 0;
      if (ctrl_wr && ctrl_wdata[0]) begin
        q.delete(); m_armed = 0;
      end else begin
        e_ovr = on && incoming && (q.size() == 16);
        if (on && rd_req && q.size() > 0) e_rd = q.pop_front();
        if (on && incoming && !e_ovr) begin
          q.push_back(b); m_armed = 1; m_left = 4 * char_time() - 1;
        end else if (m_armed && on) begin
          if (m_left == 0) begin e_tmo = 1; m_armed = 0; end
          else m_left--;
        end
      end
      if (ctrl_wr) begin m_en = ctrl_wdata[1]; m_dis = ctrl_wdata[2]; end
    end
  end

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (phase %s) %s: actual %0d expected %0d", req, phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("R1", "count", int'(count), q.size());
      cmp("R1", "full/empty", int'({full, empty}),
          int'({q.size() == 16, q.size() == 0}));
      cmp("R4", "rd_data", int'(rd_data), int'(e_rd));
      cmp("R2", "ovr_pulse", int'(ovr_pulse), int'(e_ovr));
      cmp("R6", "tmo_pulse", int'(tmo_pulse), int'(e_tmo));
      cmp("R8", "ctrl_q", int'(ctrl_q), int'({m_dis, m_en, 1'b0}));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(); @(negedge clk); endtask
  task automatic clear();
    ctrl_wr = 0; line_vld = 0; line_brk = 0; rd_req = 0;
  endtask
  task automatic idle(int n); clear(); repeat (n) step(); endtask
  task automatic cw(logic [2:0] v);
    clear(); ctrl_wr = 1; ctrl_wdata = v; step(); clear();
  endtask
  task automatic put(logic [7:0] v);
    clear(); line_vld = 1; line_byte = v; step(); clear();
  endtask
  task automatic get(); clear(); rd_req = 1; step(); clear(); endtask
  task automatic putget(logic [7:0] v);
    clear(); line_vld = 1; line_byte = v; rd_req = 1; step(); clear();
  endtask
  task automatic drain(); for (int i = 0; i < 18; i++) get(); idle(1); endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    phase = "R10"; idle(3);
    // R3: disabled, then both bits set
    phase = "R3";
    put(8'hA5); put(8'h5A); get(); idle(1);
    cw(3'b110); put(8'h11); get(); idle(2);
    cw(3'b010);
    // R1: ordering
    phase = "R1";
    for (int i = 0; i < 5; i++) put(8'(8'h30 + i));
    for (int i = 0; i < 5; i++) get();
    idle(2);
    // R4: empty reads
    phase = "R4"; get(); get(); idle(1);
    // R9: simultaneous read and write
    phase = "R9";
    put(8'h01); put(8'h02); put(8'h03);
    for (int i = 0; i < 4; i++) putget(8'(8'h40 + i));
    drain();
    // R2: overrun, plus read-with-write while full
    phase = "R2";
    for (int i = 0; i < 18; i++) put(8'(8'h80 + i));
    putget(8'hEE);
    line_brk = 1; step(); clear();
    drain();
    // R5: break with a byte on the line in the same cycle
    phase = "R5";
    clear(); line_brk = 1; line_vld = 1; line_byte = 8'h7E; step(); clear();
    put(8'h9C); get(); get(); idle(1);
    // R6: timeout, restart and pause while disabled
    phase = "R6";
    put(8'h21); idle(100);
    put(8'h22); idle(30); put(8'h23); idle(40);
    cw(3'b100); idle(200); cw(3'b010); idle(100);
    drain();
    // R7: other frame shapes
    phase = "R7";
    bit_cycles = 12'd3; width_sel = 2'd1; parity_on = 1; stop_two = 1;
    put(8'h44); idle(150);
    bit_cycles = 12'd1; width_sel = 2'd2; parity_on = 0; stop_two = 0;
    put(8'h45); idle(50);
    width_sel = 2'd3; parity_on = 1;
    put(8'h46); idle(60);
    drain();
    // R8: flush with a byte and read in the same cycle
    phase = "R8";
    bit_cycles = 12'd2; width_sel = 2'd0; parity_on = 0; stop_two = 0;
    for (int i = 0; i < 4; i++) put(8'(8'hC0 + i));
    clear(); ctrl_wr = 1; ctrl_wdata = 3'b011; line_vld = 1; line_byte = 8'hFF; rd_req = 1;
    step(); clear();
    idle(100);
    put(8'hD1); get(); idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule